// File: doc/BRIEF.md
# Word/Doubleword Shift Unit with Sign-Extending Left Shift

This block is the shift datapath of a processor execution stage. From an operation select, a word/doubleword mode flag and a signed flag it decides how to condition a 64-bit operand. It shifts that operand by an amount taken from the low bits of a second operand and delivers a 64-bit result in the same cycle. It holds no state. Every output follows the inputs combinationally, so the block sits between operand read and result write-back with no handshake.

Three operations are supported. The first is a logical left shift. The second is a right shift that fills with zeros or with the sign, as the signed flag selects. The third is a combined operation that sign-extends the low word of the operand and then shifts it left. In word mode the shift amount is six bits and the upper half of the result follows fixed rules. In doubleword mode the amount is seven bits, so any amount from 64 to 127 pushes every operand bit out. Any other select value lowers the valid flag and forces the result to zero.

Top module: `shf_unit`

## Requirements
- R1: Select 3'b000 in doubleword mode returns operand A shifted left by amount bits [6:0], truncated to 64 bits, so amounts 64 to 127 give zero.
- R2: Select 3'b000 in word mode returns A[31:0] shifted left by amount bits [5:0], truncated to 32 bits, in result bits [31:0], with result bits [63:32] zero.
- R3: Select 3'b001 in doubleword mode shifts A right by amount bits [6:0]. With the signed flag set it fills with A[63], and with the flag clear it fills with zeros. Amounts of 64 or more give all fill bits.
- R4: Select 3'b001 in word mode shifts A[31:0] right by amount bits [5:0] into result bits [31:0]. The shift fills with A[31] when signed and with zeros otherwise, and result bits [63:32] are all copies of A[31].
- R5: Select 3'b010 in word mode places A[31:0] shifted left by amount bits [5:0], truncated to 32 bits, in result bits [31:0], and result bits [63:32] are zero.
- R6: Select 3'b010 in doubleword mode first sign-extends A[31:0] to 64 bits, then shifts it left by amount bits [6:0], truncated to 64 bits.
- R7: Amount operand bits above the ones used (bit 7 and up in doubleword mode, bit 6 and up in word mode) have no effect on the result.
- R8: A zero shift amount returns the unshifted operand under each mode's rules, including when A[31] is set. For example, A = 0x80000000fb4013e2 with select 3'b010 in doubleword mode gives 0xfffffffffb4013e2.
- R9: The valid flag is 1 for selects 3'b000, 3'b001 and 3'b010, and 0 for selects 3'b011 to 3'b111. When it is 0 the result is zero.
- R10: The signed flag has no effect on selects 3'b000 and 3'b010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select: 0 left shift, 1 right shift, 2 sign-extend word then left shift |
| word_mode | input | 1 | 1 selects 32-bit word rules, 0 selects 64-bit rules |
| signed_mode | input | 1 | 1 makes the right shift fill with the sign |
| opnd_a | input | 64 | Value to be shifted |
| opnd_b | input | 64 | Shift amount source; only low bits are used |
| result | output | 64 | Shifted value |
| result_vld | output | 1 | 1 when op_sel names a supported operation |

## Verification
The block keeps no state, so a wrong internal decision shows up at once on the result for the same input vector: a wrong fill bit, a wrong stage in the shifter, or a wrong upper-half rule. There is no delayed symptom to chase, and each applied vector is compared against an independent model of the requirements. The directed vectors are chosen to expose each internal choice. They hit the stage boundaries at amounts 1, 31, 32, 63, 64 and 127, and use operands whose bit 31 and bit 63 differ, so that a confused sign source or a swapped word/doubleword width changes the visible upper half.

// File: rtl/shf_pkg.sv
package shf_pkg;

   localparam int unsigned SHF_OP_W = 3;

   typedef enum logic [SHF_OP_W-1:0] {
      SHF_OP_SHL   = 3'd0,
      SHF_OP_SHR   = 3'd1,
      SHF_OP_EXTSL = 3'd2
   } shf_op_e;

   // control decided by operand preparation, consumed by the shifter and result stage
   typedef struct packed {
      logic go_left;     // pick the left barrel
      logic fill;        // bit shifted into vacated positions
      logic low_only;    // word mode: override upper half of result
      logic upper_fill;  // value copied into the overridden upper half
   } shf_ctl_t;

endpackage

// File: rtl/shf_barrel.sv
module shf_barrel #(
   parameter int unsigned WIDTH   = 64,
   parameter int unsigned AMT_W   = 7,
   parameter bit          GO_LEFT = 1'b1
) (
   input  logic [WIDTH-1:0] din,
   input  logic [AMT_W-1:0] amt,
   input  logic             fill,
   output logic [WIDTH-1:0] dout
);

   localparam int unsigned LOG = AMT_W - 1;

   if (WIDTH != (1 << LOG)) begin : g_bad_width
      $error("shf_barrel: WIDTH must equal 2**(AMT_W-1)");
   end

   logic [WIDTH-1:0] stg [LOG+1];

   assign stg[0] = din;

   for (genvar i = 0; i < LOG; i++) begin : g_stage
      localparam int unsigned S = 1 << i;
      if (GO_LEFT) begin : g_left
         assign stg[i+1] = amt[i] ? {stg[i][WIDTH-1-S:0], {S{fill}}} : stg[i];
      end else begin : g_right
         assign stg[i+1] = amt[i] ? {{S{fill}}, stg[i][WIDTH-1:S]} : stg[i];
      end
   end

   // top amount bit means every operand bit has been pushed out
   assign dout = amt[LOG] ? {WIDTH{fill}} : stg[LOG];

endmodule

// File: rtl/shf_prep.sv
module shf_prep
   import shf_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned AMT_W  = 7
) (
   input  logic [SHF_OP_W-1:0] op_sel,
   input  logic                word_mode,
   input  logic                signed_mode,
   input  logic [DATA_W-1:0]   opnd_a,
   input  logic [AMT_W-1:0]    amt_in,
   output logic [DATA_W-1:0]   src,
   output logic [AMT_W-1:0]    amt,
   output shf_ctl_t            ctl,
   output logic                supported
);

   localparam int unsigned HALF_W = DATA_W / 2;

   logic [HALF_W-1:0] word;
   logic              wsign;
   logic [AMT_W-1:0]  amt_word;
   logic              rfill;

   assign word     = opnd_a[HALF_W-1:0];
   assign wsign    = opnd_a[HALF_W-1];
   assign amt_word = {1'b0, amt_in[AMT_W-2:0]};

   always_comb begin
      src       = opnd_a;
      amt       = amt_in;
      ctl       = '0;
      supported = 1'b1;
      rfill     = 1'b0;
      case (op_sel)
         SHF_OP_SHL, SHF_OP_EXTSL: begin
            ctl.go_left = 1'b1;
            if (word_mode) begin
               src          = {{HALF_W{1'b0}}, word};
               amt          = amt_word;
               ctl.low_only = 1'b1;
            end else if (op_sel == SHF_OP_EXTSL) begin
               src = {{HALF_W{wsign}}, word};
            end
         end
         SHF_OP_SHR: begin
            if (word_mode) begin
               rfill          = signed_mode & wsign;
               src            = {{HALF_W{rfill}}, word};
               amt            = amt_word;
               ctl.low_only   = 1'b1;
               ctl.upper_fill = wsign;
            end else begin
               rfill = signed_mode & opnd_a[DATA_W-1];
            end
            ctl.fill = rfill;
         end
         default: begin
            supported = 1'b0;
            src       = '0;
            amt       = '0;
         end
      endcase
   end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
   import shf_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [2:0]        op_sel,
   input  logic              word_mode,
   input  logic              signed_mode,
   input  logic [63:0]       opnd_a,
   input  logic [63:0]       opnd_b,
   output logic [63:0]       result,
   output logic              result_vld
);

   localparam int unsigned LOG    = $clog2(DATA_W);
   localparam int unsigned AMT_W  = LOG + 1;
   localparam int unsigned HALF_W = DATA_W / 2;

   if (DATA_W != 64) begin : g_bad_width
      $error("shf_unit: port widths are fixed at 64 bits");
   end
   if (SHF_OP_W != 3) begin : g_bad_op
      $error("shf_unit: op_sel port is 3 bits");
   end

   logic [DATA_W-1:0] src;
   logic [AMT_W-1:0]  amt;
   shf_ctl_t          ctl;
   logic              supported;
   logic [DATA_W-1:0] left_q, right_q, sel_q;
   logic              unused_amt_hi;

   assign unused_amt_hi = ^opnd_b[DATA_W-1:AMT_W];

   shf_prep #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_prep (
      .op_sel      (op_sel),
      .word_mode   (word_mode),
      .signed_mode (signed_mode),
      .opnd_a      (opnd_a),
      .amt_in      (opnd_b[AMT_W-1:0]),
      .src         (src),
      .amt         (amt),
      .ctl         (ctl),
      .supported   (supported)
   );

   shf_barrel #(.WIDTH(DATA_W), .AMT_W(AMT_W), .GO_LEFT(1'b1)) u_left (
      .din  (src),
      .amt  (amt),
      .fill (ctl.fill),
      .dout (left_q)
   );

   shf_barrel #(.WIDTH(DATA_W), .AMT_W(AMT_W), .GO_LEFT(1'b0)) u_right (
      .din  (src),
      .amt  (amt),
      .fill (ctl.fill),
      .dout (right_q)
   );

   assign sel_q = ctl.go_left ? left_q : right_q;

   always_comb begin
      if (!supported)
         result = '0;
      else if (ctl.low_only)
         result = {{HALF_W{ctl.upper_fill}}, sel_q[HALF_W-1:0]};
      else
         result = sel_q;
      result_vld = supported;
   end

   // port-level checks next to the result stage
   always_comb begin
      if (op_sel > 3'd2) begin
         a_r9_unsupported_quiet: assert (!result_vld && result == '0)
            else $error("R9: unsupported select produced output");
      end else begin
         a_r9_supported_valid: assert (result_vld)
            else $error("R9: supported select not valid");
      end
      if (op_sel == 3'd0 && !word_mode && opnd_b[6]) begin
         a_r1_big_left_zero: assert (result == '0)
            else $error("R1: large left shift not zero");
      end
      if (op_sel == 3'd0 && word_mode) begin
         a_r2_word_left_upper: assert (result[63:32] == '0)
            else $error("R2: word left shift upper half not zero");
      end
      if (op_sel == 3'd1 && !word_mode && signed_mode && opnd_b[6]) begin
         a_r3_big_sra_fill: assert (result == {64{opnd_a[63]}})
            else $error("R3: large arithmetic shift not sign fill");
      end
      if (op_sel == 3'd1 && word_mode) begin
         a_r4_word_right_upper: assert (result[63:32] == {32{opnd_a[31]}})
            else $error("R4: word right shift upper half wrong");
      end
      if (op_sel == 3'd2 && word_mode) begin
         a_r5_ext_word_upper: assert (result[63:32] == '0)
            else $error("R5: word extend-shift upper half not zero");
      end
      if (op_sel == 3'd2 && !word_mode && opnd_b[6:0] == 7'd0) begin
         a_r6_ext_zero_amt: assert (result == {{32{opnd_a[31]}}, opnd_a[31:0]})
            else $error("R6: extend-shift by zero not sign-extended word");
      end
   end

endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;

   logic        clk = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic        word_mode = 1'b0;
   logic        signed_mode = 1'b0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [63:0] result;
   logic        result_vld;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   shf_unit u_shf_unit (
      .op_sel      (op_sel),
      .word_mode   (word_mode),
      .signed_mode (signed_mode),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .result      (result),
      .result_vld  (result_vld)
   );

   // model of the requirements: {valid, result}
   function automatic logic [64:0] model(input logic [2:0] op, input logic wm,
                                         input logic sg, input logic [63:0] a,
                                         input logic [63:0] b);
      logic [31:0]        lo;
      logic signed [31:0] s32;
      logic signed [63:0] s64;
      logic [63:0]        r;
      r = '0;
      case (op)
         3'd0: begin
            if (wm) begin lo = a[31:0] << b[5:0]; r = {32'h0, lo}; end
            else r = a << b[6:0];
         end
         3'd1: begin
            if (wm) begin
               s32 = a[31:0];
               lo  = sg ? 32'(s32 >>> b[5:0]) : (a[31:0] >> b[5:0]);
               r   = {{32{a[31]}}, lo};
            end else begin
               s64 = a;
               r   = sg ? 64'(s64 >>> b[6:0]) : (a >> b[6:0]);
            end
         end
         3'd2: begin
            if (wm) begin lo = a[31:0] << b[5:0]; r = {32'h0, lo}; end
            else r = {{32{a[31]}}, a[31:0]} << b[6:0];
         end
         default: return {1'b0, 64'h0};
      endcase
      return {1'b1, r};
   endfunction

   task automatic apply(input logic [2:0] op, input logic wm, input logic sg,
                        input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      op_sel = op; word_mode = wm; signed_mode = sg; opnd_a = a; opnd_b = b;
      #1;
   endtask

   task automatic expect_out(input string tag, input logic vexp, input logic [63:0] rexp);
      n_run++;
      if (result_vld !== vexp || result !== rexp) begin
         n_fail++;
         $display("FAIL %s: actual vld=%0b res=%h expected vld=%0b res=%h",
                  tag, result_vld, result, vexp, rexp);
      end
   endtask

   task automatic run(input string tag, input logic [2:0] op, input logic wm,
                      input logic sg, input logic [63:0] a, input logic [63:0] b);
      logic [64:0] e;
      apply(op, wm, sg, a, b);
      e = model(op, wm, sg, a, b);
      expect_out(tag, e[64], e[63:0]);
   endtask

   task automatic t_idle;
      apply(3'd0, 1'b0, 1'b0, '0, '0);
      expect_out("R9 idle inputs", 1'b1, 64'h0);
   endtask

   task automatic t_shl64;   // R1
      run("R1 shl64 1", 3'd0, 1'b0, 1'b0, 64'h8000_0000_0000_0001, 64'd1);
      run("R1 shl64 63", 3'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0003, 64'd63);
      apply(3'd0, 1'b0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd64);
      expect_out("R1 shl64 64 gives zero", 1'b1, 64'h0);
      run("R1 shl64 127", 3'd0, 1'b0, 1'b0, 64'h1234_5678_9abc_def0, 64'd127);
   endtask

   task automatic t_shl32;   // R2
      apply(3'd0, 1'b1, 1'b0, 64'hdead_beef_8000_0001, 64'd4);
      expect_out("R2 shl32 4", 1'b1, 64'h0000_0000_0000_0010);
      run("R2 shl32 31", 3'd0, 1'b1, 1'b0, 64'hffff_ffff_0000_0001, 64'd31);
      run("R2 shl32 32", 3'd0, 1'b1, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd32);
   endtask

   task automatic t_shr64;   // R3
      apply(3'd1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd4);
      expect_out("R3 sra64 4", 1'b1, 64'hf800_0000_0000_0000);
      run("R3 srl64 4", 3'd1, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 64'd4);
      run("R3 sra64 100", 3'd1, 1'b0, 1'b1, 64'h9000_0000_0000_0000, 64'd100);
      run("R3 srl64 64", 3'd1, 1'b0, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd64);
      run("R3 sra64 pos", 3'd1, 1'b0, 1'b1, 64'h7fff_0000_0000_0000, 64'd63);
   endtask

   task automatic t_shr32;   // R4
      apply(3'd1, 1'b1, 1'b1, 64'h0000_0000_8000_0000, 64'd4);
      expect_out("R4 sra32 4", 1'b1, 64'hffff_ffff_f800_0000);
      apply(3'd1, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 64'd4);
      expect_out("R4 srl32 4", 1'b1, 64'hffff_ffff_0800_0000);
      run("R4 srl32 pos word", 3'd1, 1'b1, 1'b0, 64'hffff_ffff_7000_0000, 64'd8);
      run("R4 sra32 40", 3'd1, 1'b1, 1'b1, 64'h0000_0000_8000_1234, 64'd40);
   endtask

   task automatic t_ext32;   // R5
      apply(3'd2, 1'b1, 1'b0, 64'h1111_1111_8000_00ff, 64'd8);
      expect_out("R5 ext32 8", 1'b1, 64'h0000_0000_0000_ff00);
      run("R5 ext32 63", 3'd2, 1'b1, 1'b0, 64'h0000_0000_ffff_ffff, 64'd63);
   endtask

   task automatic t_ext64;   // R6
      apply(3'd2, 1'b0, 1'b0, 64'h0000_0000_8000_0001, 64'd4);
      expect_out("R6 ext64 4", 1'b1, 64'hffff_fff8_0000_0010);
      run("R6 ext64 pos", 3'd2, 1'b0, 1'b0, 64'hffff_ffff_7000_0001, 64'd32);
      run("R6 ext64 127", 3'd2, 1'b0, 1'b0, 64'h0000_0000_8000_0001, 64'd127);
   endtask

   task automatic t_amount_high_bits;   // R7
      apply(3'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 64'hffff_ffff_ffff_ff05);
      expect_out("R7 shl64 high amount bits", 1'b1, 64'h0000_0000_0000_0020);
      apply(3'd1, 1'b1, 1'b0, 64'h0000_0000_0000_0100, 64'hffff_ffff_ffff_ffc4);
      expect_out("R7 srl32 high amount bits", 1'b1, 64'h0000_0000_0000_0010);
   endtask

   task automatic t_zero_amount;   // R8
      apply(3'd2, 1'b0, 1'b0, 64'h8000_0000_fb40_13e2, 64'd0);
      expect_out("R8 ext64 zero", 1'b1, 64'hffff_ffff_fb40_13e2);
      apply(3'd2, 1'b0, 1'b0, 64'h0000_0101_8012_2900, 64'd0);
      expect_out("R8 ext64 zero second", 1'b1, 64'hffff_ffff_8012_2900);
      apply(3'd2, 1'b1, 1'b0, 64'h8000_0000_fb40_13e2, 64'd0);
      expect_out("R8 ext32 zero", 1'b1, 64'h0000_0000_fb40_13e2);
      apply(3'd1, 1'b1, 1'b0, 64'h8000_0000_fb40_13e2, 64'd0);
      expect_out("R8 srl32 zero", 1'b1, 64'hffff_ffff_fb40_13e2);
      apply(3'd1, 1'b0, 1'b1, 64'h8000_0000_fb40_13e2, 64'd0);
      expect_out("R8 sra64 zero", 1'b1, 64'h8000_0000_fb40_13e2);
   endtask

   task automatic t_unsupported;   // R9
      for (int op = 3; op < 8; op++) begin
         apply(3'(op), 1'b0, 1'b1, 64'hffff_ffff_ffff_ffff, 64'd3);
         expect_out("R9 unsupported select", 1'b0, 64'h0);
      end
   endtask

   task automatic t_signed_ignored;   // R10
      apply(3'd0, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'd2);
      expect_out("R10 shl signed flag", 1'b1, 64'h0000_0000_0000_0004);
      apply(3'd2, 1'b1, 1'b1, 64'h0000_0000_8000_0001, 64'd1);
      expect_out("R10 ext32 signed flag", 1'b1, 64'h0000_0000_0000_0002);
   endtask

   task automatic t_random;   // R1 to R6 mixed, plus R9
      for (int k = 0; k < 400; k++) begin
         logic [2:0]  op;
         logic [63:0] a, b;
         op = 3'($urandom_range(0, 3));
         a  = {$urandom, $urandom};
         b  = {$urandom, $urandom};
         run("R1/R3/R4/R6 random", op, 1'($urandom), 1'($urandom), a, b);
      end
   endtask

   initial begin
      t_idle();
      t_shl64();
      t_shl32();
      t_shr64();
      t_shr32();
      t_ext32();
      t_ext64();
      t_amount_high_bits();
      t_zero_amount();
      t_unsupported();
      t_signed_ignored();
      t_random();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule